// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

This block is a bus-mapped timer with a set of independent channels. Each channel holds a 64-bit interval and a 64-bit down counter. A per-channel prescaler divides the block clock by a power of two, and the counter takes one step per prescaled tick. When a channel expires, it raises a bit in a shared status word. A periodic channel then reloads itself from its interval. A one-shot channel stops at zero and drops its own enable.

Software works the block through a word-wide register port that has separate read and write strobes. It writes the interval as two words. It then writes the control word with both enable and reload set. The next cycle copies the interval into the counter. The shared enable word chooses which channels may drive the single level interrupt. Software clears status bits by writing ones to them. When enable is cleared, the counter keeps stepping for a short drain window before it halts. Software reads the count low word first. That read also captures the high word, so the two halves always belong to the same 64-bit value.

Top module: `multi_dntimer`

## Requirements
- R1: After reset, every register reads zero and the interrupt is low. This covers interrupt enable, status, and each channel's control, interval, count and captured high word.
- R2: The register map is fixed.
  - Interrupt enable is at offset 0x00 and status is at 0x04. In both, bit n belongs to channel n.
  - Channel n's control word is at 0x20*n+0x10. Its fields are: bit 0 enable, bit 1 reload, bits 6:4 prescaler select, bit 7 one-shot (1) or periodic (0). All other bits read as zero.
  - The interval low and high words are at 0x20*n+0x14 and 0x20*n+0x18.
  - The count low and high words are at 0x20*n+0x1C and 0x20*n+0x20.
- R3: When enable and reload are both 1 in the control word, the counter holds the interval on the following cycle. The reload bit then reads back as 0.
- R4: With prescaler select s, the counter steps once every 2^s clock cycles. The first step lands 2^s cycles after the load cycle.
- R5: A tick that arrives while the count is zero is an expiry. On expiry the channel's status bit sets. A periodic channel reloads its interval, so the expiry period is interval+1 ticks.
- R6: On expiry, a one-shot channel leaves its count at zero and clears its enable bit. Its one-shot and select fields stay as they were.
- R7: When a control write turns enable from 1 to 0, the counter steps on that cycle's edge and on the two edges that follow. It then holds its value.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an expiry and a clearing write hit the same bit in the same cycle, the bit stays set.
- R9: The interrupt output is high exactly when some channel has both its status bit and its enable bit set.
- R10: A read strobe on a count low word captures that channel's high count word in the same cycle. The high-word address then returns the captured value and not the live one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and timer source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register being accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, used to capture the high count word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt |

## Verification
An expiry and a software write-one-to-clear can land on the same status bit in the same clock edge. The bench loads a periodic channel with a short interval and counts the register stages from the enabling write to the expiry tick. It then issues the clearing write so that it reaches that exact edge. The status bit must still read 1 afterwards, and a later clearing write with no competing expiry must bring it to 0. A write of zeros in between must leave it at 1.

// File: rtl/tmr_pkg.sv
// Shared constants and the control-field type for the multi-channel timer.
// Assumes word-aligned byte addressing on the register port.
package tmr_pkg;
    localparam int SEL_W     = 3;   // prescaler select width
    localparam int STOP_LAT  = 2;   // extra counting edges after enable drops
    localparam int OFF_IEN   = 'h00;
    localparam int OFF_IST   = 'h04;
    localparam int CH_BASE   = 'h10;
    localparam int CH_STRIDE = 'h20;
    localparam int OFF_CTL   = 'h00;
    localparam int OFF_IVLO  = 'h04;
    localparam int OFF_IVHI  = 'h08;
    localparam int OFF_CNLO  = 'h0C;
    localparam int OFF_CNHI  = 'h10;

    typedef struct packed {
        logic             oneshot;
        logic [SEL_W-1:0] sel;
        logic             reload;
        logic             enable;
    } ctl_t;
endpackage

// File: rtl/tmr_prescaler.sv
// Power-of-two tick generator. Produces tick when the low sel bits of a
// free-running phase counter are all ones; clr restarts the phase.
// Assumes tick is only consumed in cycles where adv is high.
module tmr_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PH_W = (1 << SEL_W) - 1;

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] mask;

    // Mask of the phase bits that must be ones for a tick.
    always_comb begin
        mask = PH_W'((32'd1 << sel) - 32'd1);
        tick = ((phase_q & mask) == mask);
    end

    // Phase counter: restart on load, advance while the channel counts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (clr)
            phase_q <= '0;
        else if (adv)
            phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/tmr_channel.sv
// One timer channel: control fields, 64-bit interval, 64-bit down counter,
// stop-drain window and the high-word capture for consistent reads.
// Assumes control writes take priority over self-clearing of control bits.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int STOP_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  ctl_t              ctl_wr,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              snap_en,
    output ctl_t              ctl_q,
    output logic [2*DATA_W-1:0] ivl_q,
    output logic [2*DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0] snap_hi,
    output logic              expire
);
    localparam int CNT_W = 2 * DATA_W;
    localparam int DRN_W = $clog2(STOP_LAT + 1);

    logic [DRN_W-1:0] drain_q;
    logic             gate;
    logic             load;
    logic             tick;
    logic             step;

    // Counting is allowed while enabled or while the stop window drains.
    always_comb begin
        gate   = ctl_q.enable | (drain_q != '0);
        load   = ctl_q.reload & ctl_q.enable;
        step   = gate & ~load & tick;
        expire = step & (cnt_q == '0);
    end

    tmr_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .adv   (gate & ~load),
        .sel   (ctl_q.sel),
        .tick  (tick)
    );

    // Control fields and the drain window after enable is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            drain_q <= '0;
        end else if (ctl_we) begin
            ctl_q   <= ctl_wr;
            drain_q <= (ctl_q.enable && !ctl_wr.enable) ? DRN_W'(STOP_LAT) : '0;
        end else begin
            if (load)
                ctl_q.reload <= 1'b0;
            if (expire && ctl_q.oneshot)
                ctl_q.enable <= 1'b0;
            if (drain_q != '0)
                drain_q <= drain_q - 1'b1;
        end
    end

    // Interval words written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ivl_q <= '0;
        else begin
            if (lo_we)
                ivl_q[DATA_W-1:0] <= wdata;
            if (hi_we)
                ivl_q[CNT_W-1:DATA_W] <= wdata;
        end
    end

    // Down counter: load, step, and reload or park at zero on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= ivl_q;
        else if (step) begin
            if (cnt_q == '0)
                cnt_q <= ctl_q.oneshot ? '0 : ivl_q;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // High-word capture taken with each low-word read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_hi <= '0;
        else if (snap_en)
            snap_hi <= cnt_q[CNT_W-1:DATA_W];
    end
endmodule

// File: rtl/tmr_irq_ctrl.sv
// Shared interrupt enable and write-one-to-clear status for all channels.
// An expiry in the same cycle as a clearing write keeps the bit set.
module tmr_irq_ctrl #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ien_we,
    input  logic              st_we,
    input  logic [NUM_CH-1:0] wbits,
    input  logic [NUM_CH-1:0] expire,
    output logic [NUM_CH-1:0] ien_q,
    output logic [NUM_CH-1:0] st_q,
    output logic              irq
);
    // Interrupt enable word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_q <= '0;
        else if (ien_we)
            ien_q <= wbits;
    end

    // Status bits: set by expiry, cleared by writing ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= expire | (st_q & ~(st_we ? wbits : '0));
    end

    // Level interrupt from enabled pending bits.
    always_comb irq = |(st_q & ien_q);
endmodule

// File: rtl/multi_dntimer.sv
// Top of the multi-channel down-counting timer: address decode, channel
// array and read multiplexer. Assumes one bus access per cycle and
// DATA_W >= NUM_CH and DATA_W >= 8.
module multi_dntimer
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    ctl_t              ctl_arr [NUM_CH];
    logic [CNT_W-1:0]  ivl_arr [NUM_CH];
    logic [CNT_W-1:0]  cnt_arr [NUM_CH];
    logic [DATA_W-1:0] snp_arr [NUM_CH];
    logic [NUM_CH-1:0] exp_vec;
    logic [NUM_CH-1:0] en_vec;
    logic [NUM_CH-1:0] os_vec;
    logic [NUM_CH-1:0] ctl_we_vec;
    logic [NUM_CH-1:0] ien_vec;
    logic [NUM_CH-1:0] st_vec;
    logic              ien_we;
    logic              st_we;
    ctl_t              ctl_wr;

    // Shared-register strobes and control-field extraction.
    always_comb begin
        ien_we = bus_wr && (bus_addr == ADDR_W'(OFF_IEN));
        st_we  = bus_wr && (bus_addr == ADDR_W'(OFF_IST));
        ctl_wr = '{oneshot: bus_wdata[7], sel: bus_wdata[6:4],
                   reload:  bus_wdata[1], enable: bus_wdata[0]};
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int BASE = CH_BASE + CH_STRIDE * i;
        logic lo_we, hi_we, snap_en;

        // Per-channel write and capture strobes.
        always_comb begin
            ctl_we_vec[i] = bus_wr && (bus_addr == ADDR_W'(BASE + OFF_CTL));
            lo_we         = bus_wr && (bus_addr == ADDR_W'(BASE + OFF_IVLO));
            hi_we         = bus_wr && (bus_addr == ADDR_W'(BASE + OFF_IVHI));
            snap_en       = bus_rd && (bus_addr == ADDR_W'(BASE + OFF_CNLO));
            en_vec[i]     = ctl_arr[i].enable;
            os_vec[i]     = ctl_arr[i].oneshot;
        end

        tmr_channel #(.DATA_W(DATA_W), .STOP_LAT(STOP_LAT)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_we  (ctl_we_vec[i]),
            .ctl_wr  (ctl_wr),
            .lo_we   (lo_we),
            .hi_we   (hi_we),
            .wdata   (bus_wdata),
            .snap_en (snap_en),
            .ctl_q   (ctl_arr[i]),
            .ivl_q   (ivl_arr[i]),
            .cnt_q   (cnt_arr[i]),
            .snap_hi (snp_arr[i]),
            .expire  (exp_vec[i])
        );
    end

    tmr_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ien_we (ien_we),
        .st_we  (st_we),
        .wbits  (bus_wdata[NUM_CH-1:0]),
        .expire (exp_vec),
        .ien_q  (ien_vec),
        .st_q   (st_vec),
        .irq    (irq)
    );

    // Read multiplexer over shared and per-channel registers.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_IEN))
            bus_rdata = DATA_W'(ien_vec);
        if (bus_addr == ADDR_W'(OFF_IST))
            bus_rdata = DATA_W'(st_vec);
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFF_CTL))
                bus_rdata = DATA_W'({ctl_arr[c].oneshot, ctl_arr[c].sel, 2'b00,
                                     ctl_arr[c].reload, ctl_arr[c].enable});
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFF_IVLO))
                bus_rdata = ivl_arr[c][DATA_W-1:0];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFF_IVHI))
                bus_rdata = ivl_arr[c][CNT_W-1:DATA_W];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFF_CNLO))
                bus_rdata = cnt_arr[c][DATA_W-1:0];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFF_CNHI))
                bus_rdata = snp_arr[c];
        end
    end
endmodule

// File: rtl/multi_dntimer_chk.sv
// Property checker for the timer: status set/clear/hold, one-shot stop and
// interrupt qualification. Attached to the top by the bind below.
module multi_dntimer_chk #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              st_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NUM_CH-1:0] st_vec,
    input logic [NUM_CH-1:0] exp_vec,
    input logic [NUM_CH-1:0] en_vec,
    input logic [NUM_CH-1:0] os_vec,
    input logic [NUM_CH-1:0] ctl_we_vec
);
    p_expiry_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_vec != '0) |=> ((st_vec & $past(exp_vec)) == $past(exp_vec)));

    p_w1c_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && ((bus_wdata[NUM_CH-1:0] & ~exp_vec) != '0))
        |=> ((st_vec & $past(bus_wdata[NUM_CH-1:0] & ~exp_vec)) == '0));

    p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_we && exp_vec == '0) |=> (st_vec == $past(st_vec)));

    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((exp_vec & os_vec & ~ctl_we_vec) != '0)
        |=> ((en_vec & $past(exp_vec & os_vec & ~ctl_we_vec)) == '0));

    p_irq_needs_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_vec != '0));
endmodule

bind multi_dntimer multi_dntimer_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .st_we      (st_we),
    .bus_wdata  (bus_wdata),
    .st_vec     (st_vec),
    .exp_vec    (exp_vec),
    .en_vec     (en_vec),
    .os_vec     (os_vec),
    .ctl_we_vec (ctl_we_vec)
);

// File: tb/multi_dntimer_test.sv
// Directed bench: one task per scenario, each checking its own results.
module multi_dntimer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    multi_dntimer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [7:0] a_ctl(int n);  return 8'(32 * n + 'h10); endfunction
    function automatic logic [7:0] a_ivlo(int n); return 8'(32 * n + 'h14); endfunction
    function automatic logic [7:0] a_ivhi(int n); return 8'(32 * n + 'h18); endfunction
    function automatic logic [7:0] a_cnlo(int n); return 8'(32 * n + 'h1C); endfunction
    function automatic logic [7:0] a_cnhi(int n); return 8'(32 * n + 'h20); endfunction
    localparam logic [7:0] A_IEN = 8'h00;
    localparam logic [7:0] A_IST = 8'h04;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Called at a negedge; the write lands on the next rising edge.
    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Strobed read: samples pre-edge data, strobe acts on the next edge.
    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Unstrobed look at a register, no clock advance.
    task automatic peek(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        peek(A_IEN, d);     check("R1 ien", d, 0);
        peek(A_IST, d);     check("R1 status", d, 0);
        peek(a_ctl(0), d);  check("R1 ctl0", d, 0);
        peek(a_ivhi(2), d); check("R1 ivl2 hi", d, 0);
        peek(a_cnlo(3), d); check("R1 cnt3 lo", d, 0);
        peek(a_cnhi(1), d); check("R1 cnt1 hi", d, 0);
        check("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_load();
        logic [31:0] d;
        do_reset();
        bus_write(a_ivlo(1), 32'h0000_1234);
        bus_write(a_ivhi(1), 32'h0000_00A5);
        bus_write(a_ctl(1), 32'h0000_00B3);  // one-shot, sel 3, reload, enable
        idle(1);
        peek(a_ivlo(1), d); check("R2 ivl lo readback", d, 32'h1234);
        peek(a_ivhi(1), d); check("R2 ivl hi readback", d, 32'hA5);
        peek(a_ctl(1), d);  check("R3 reload self-clears", d, 32'hB1);
        bus_read(a_cnlo(1), d); check("R3 count lo loaded", d, 32'h1234);
        peek(a_cnhi(1), d); check("R3 count hi loaded", d, 32'hA5);
    endtask

    task automatic t_prescale();
        logic [31:0] d;
        do_reset();
        bus_write(a_ivlo(0), 100);
        bus_write(a_ctl(0), 32'h23);  // sel 2, periodic
        idle(8);
        peek(a_cnlo(0), d); check("R4 one step after 8", d, 99);
        idle(1);
        peek(a_cnlo(0), d); check("R4 second step at 9", d, 98);
    endtask

    task automatic t_periodic();
        logic [31:0] d;
        do_reset();
        bus_write(a_ivlo(2), 2);
        bus_write(a_ctl(2), 32'h03);
        idle(3);
        peek(a_cnlo(2), d); check("R5 count at zero", d, 0);
        peek(A_IST, d);     check("R5 no expiry yet", d, 0);
        idle(1);
        peek(a_cnlo(2), d); check("R5 periodic reload", d, 2);
        peek(A_IST, d);     check("R5 status set", d, 32'h4);
        idle(2);
        peek(a_cnlo(2), d); check("R5 second period zero", d, 0);
        idle(1);
        peek(a_cnlo(2), d); check("R5 second reload", d, 2);
    endtask

    task automatic t_oneshot();
        logic [31:0] d;
        do_reset();
        bus_write(a_ivlo(3), 3);
        bus_write(a_ctl(3), 32'h83);
        idle(4);
        peek(a_ctl(3), d);  check("R6 enabled before expiry", d, 32'h81);
        peek(A_IST, d);     check("R6 status clear before", d, 0);
        idle(1);
        peek(a_ctl(3), d);  check("R6 enable dropped", d, 32'h80);
        peek(A_IST, d);     check("R6 status set", d, 32'h8);
        idle(5);
        peek(a_cnlo(3), d); check("R6 count parked at zero", d, 0);
    endtask

    task automatic t_stop();
        logic [31:0] d;
        do_reset();
        bus_write(a_ivlo(0), 1000);
        bus_write(a_ctl(0), 32'h03);
        idle(10);
        bus_write(a_ctl(0), 32'h00);
        peek(a_cnlo(0), d); check("R7 at disable edge", d, 990);
        idle(1);
        peek(a_cnlo(0), d); check("R7 drain step 1", d, 989);
        idle(1);
        peek(a_cnlo(0), d); check("R7 drain step 2", d, 988);
        idle(5);
        peek(a_cnlo(0), d); check("R7 halted", d, 988);
    endtask

    task automatic t_w1c_race();
        logic [31:0] d;
        do_reset();
        bus_write(a_ivlo(1), 5);
        bus_write(a_ctl(1), 32'h03);
        idle(6);
        bus_write(A_IST, 32'h2);  // lands on the expiry edge
        peek(A_IST, d); check("R8 expiry beats clear", d, 32'h2);
        bus_write(A_IST, 32'h0);
        peek(A_IST, d); check("R8 zero write no effect", d, 32'h2);
        bus_write(A_IST, 32'h2);
        peek(A_IST, d); check("R8 one clears", d, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        do_reset();
        bus_write(a_ivlo(0), 1);
        bus_write(a_ctl(0), 32'h83);
        idle(4);
        peek(A_IST, d); check("R9 status pending", d, 32'h1);
        check("R9 masked irq low", 32'(irq), 0);
        bus_write(A_IEN, 32'h1);
        check("R9 irq high when enabled", 32'(irq), 1);
        bus_write(A_IEN, 32'h2);
        check("R9 other enable no irq", 32'(irq), 0);
        bus_write(A_IEN, 32'h1);
        bus_write(A_IST, 32'h1);
        check("R9 irq low after clear", 32'(irq), 0);
    endtask

    task automatic t_snapshot();
        logic [31:0] d;
        do_reset();
        bus_write(a_ivlo(2), 1);
        bus_write(a_ivhi(2), 1);
        bus_write(a_ctl(2), 32'h03);
        idle(1);
        bus_read(a_cnlo(2), d); check("R10 low at capture", d, 1);
        idle(2);
        peek(a_cnhi(2), d); check("R10 high is captured", d, 1);
        peek(a_cnlo(2), d); check("R10 live low moved", d, 32'hFFFF_FFFE);
        bus_read(a_cnlo(2), d);
        peek(a_cnhi(2), d); check("R10 new capture", d, 0);
    endtask

    initial begin
        t_reset();
        t_load();
        t_prescale();
        t_periodic();
        t_oneshot();
        t_stop();
        t_w1c_race();
        t_irq();
        t_snapshot();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule